// File: doc/BRIEF.md
# Serial CRC-8 Identity Word Checker

This block checks the integrity of a 64-bit identity word as it arrives one bit at a time from a single-wire bus receiver. Each bit comes with a valid strobe, least significant bit first. The first 56 bits are an 8-bit family code followed by a 48-bit serial number. The last 8 bits are the check byte that the sender stored.

The block runs an 8-bit CRC over the 56 leading bits. It then compares that result with the trailing byte. One cycle after the 64th bit it raises a done flag and a match flag. The running CRC register is visible at all times, so a host can read the CRC of the identity body.

A clear input starts a new word. A build parameter selects how the comparison is done: either an explicit compare against the received byte, or a residue check that runs the CRC over all 64 bits and tests for zero. Both ways give the same verdict.

Top module: `idCrcChecker`

## Requirements
- R1: After reset, `done` and `match` are 0 and `crcValue` is 00h.
- R2: The CRC starts at 00h. For each accepted bit among the first 56, the bit is XORed with CRC bit 0, the register shifts right by one, and 8Ch is XORed in when that XOR result was 1. `crcValue` shows the register one cycle after each strobe. For the body bytes 02h,1Ch,B8h,01h,00h,00h,00h (sent in that order, each LSB first), it reads A2h.
- R3: Bits 57 to 64 do not change `crcValue`.
- R4: `done` is 0 until the 64th accepted bit. It reads 1 in the cycle after that strobe.
- R5: `match` is 1 together with `done` exactly when the last 8 bits, taken as a byte whose least significant bit is bit 57 of the word, equal the CRC of the first 56 bits. Otherwise `match` is 0.
- R6: `clear` returns `done`, `match` and `crcValue` to 0 one cycle later. When `clear` and a valid strobe come in the same cycle, `clear` wins and the bit is dropped.
- R7: Strobes after the 64th bit and before a clear change none of `done`, `match` or `crcValue`.
- R8: Bits presented without `bitValid` have no effect.
- R9: The residue variant (`RESIDUE_CHECK`=1) gives the same `match` value as the compare variant for every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Start a new word |
| bitValid | input | 1 | Strobe: `bitIn` holds a received bit |
| bitIn | input | 1 | Received data bit |
| done | output | 1 | All 64 bits have been received |
| match | output | 1 | The check byte agrees with the computed CRC |
| crcValue | output | 8 | Running CRC register |

## Verification
The bench targets the boundary at bit 56. A design that kept feeding the check byte into the CRC would show a changed `crcValue` and a wrong verdict. At the 63rd and 64th bits, an off-by-one counter would raise `done` early or late. Surplus strobes after a full word are also tested: a design that failed to ignore them would change `crcValue` or flip `match`. A clear that arrives together with a strobe is checked, because a design that let the bit through would corrupt the next word. Both variants run side by side on every vector. A wrong residue test would then disagree with the compare verdict on words that are corrupt or all zero.

// File: rtl/idcrc_pkg.sv
package idcrc_pkg;
  localparam int CRC_W = 8;
  localparam logic [CRC_W-1:0] POLY_REFL = 8'h8C;

  typedef struct packed {
    logic clr;     // restart the word
    logic crcEn;   // bit belongs to the identity body
    logic capEn;   // bit belongs to the stored check byte
    logic lastBit; // final bit of the word
  } strobe_t;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? POLY_REFL : '0);
  endfunction
endpackage

// File: rtl/idCrcCtrl.sv
module idCrcCtrl
  import idcrc_pkg::*;
#(
  parameter int WORD_BITS = 64
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    clear,
  input  logic    bitValid,
  output strobe_t strobes,
  output logic    done
);
  localparam int DATA_BITS = WORD_BITS - CRC_W;
  localparam int CNT_W = $clog2(WORD_BITS + 1);

  logic [CNT_W-1:0] bitCount;
  logic accept;

  assign accept = bitValid && !clear && (bitCount < CNT_W'(WORD_BITS));

  always_comb begin
    strobes.clr     = clear;
    strobes.crcEn   = accept && (bitCount < CNT_W'(DATA_BITS));
    strobes.capEn   = accept && (bitCount >= CNT_W'(DATA_BITS));
    strobes.lastBit = accept && (bitCount == CNT_W'(WORD_BITS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
      done     <= 1'b0;
    end else if (clear) begin
      bitCount <= '0;
      done     <= 1'b0;
    end else begin
      if (accept) bitCount <= bitCount + 1'b1;
      if (strobes.lastBit) done <= 1'b1;
    end
  end

  // R4
  done_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (bitCount == CNT_W'(WORD_BITS)));

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= CNT_W'(WORD_BITS));

  // R6
  clear_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (!done && bitCount == '0));
endmodule

// File: rtl/idCrcDatapath.sv
module idCrcDatapath
  import idcrc_pkg::*;
#(
  parameter bit RESIDUE_CHECK = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic             bitIn,
  output logic [CRC_W-1:0] crcReg,
  output logic             match
);
  logic verdict;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              crcReg <= '0;
    else if (strobes.clr)   crcReg <= '0;
    else if (strobes.crcEn) crcReg <= crcStep(crcReg, bitIn);
  end

  generate
    if (RESIDUE_CHECK) begin : g_residue
      logic [CRC_W-1:0] resReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                              resReg <= '0;
        else if (strobes.clr)                   resReg <= '0;
        else if (strobes.crcEn || strobes.capEn) resReg <= crcStep(resReg, bitIn);
      end
      assign verdict = (crcStep(resReg, bitIn) == '0);
    end else begin : g_compare
      logic [CRC_W-1:0] rxByte;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              rxByte <= '0;
        else if (strobes.clr)   rxByte <= '0;
        else if (strobes.capEn) rxByte <= {bitIn, rxByte[CRC_W-1:1]};
      end
      assign verdict = ({bitIn, rxByte[CRC_W-1:1]} == crcReg);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                match <= 1'b0;
    else if (strobes.clr)     match <= 1'b0;
    else if (strobes.lastBit) match <= verdict;
  end

  // R3
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.crcEn && !strobes.clr) |=> $stable(crcReg));

  // R6
  clear_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clr |=> (!match && crcReg == '0));
endmodule

// File: rtl/idCrcChecker.sv
module idCrcChecker
  import idcrc_pkg::*;
#(
  parameter int WORD_BITS     = 64,
  parameter bit RESIDUE_CHECK = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             bitValid,
  input  logic             bitIn,
  output logic             done,
  output logic             match,
  output logic [CRC_W-1:0] crcValue
);
  strobe_t strobes;

  idCrcCtrl #(.WORD_BITS(WORD_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .clear(clear), .bitValid(bitValid),
    .strobes(strobes), .done(done)
  );

  idCrcDatapath #(.RESIDUE_CHECK(RESIDUE_CHECK)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bitIn(bitIn),
    .crcReg(crcValue), .match(match)
  );

  // R5
  match_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    match |-> done);

  // R7
  frozen_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !clear) |=> (done && $stable(match) && $stable(crcValue)));
endmodule

// File: tb/test_idCrcChecker.sv
module test_idCrcChecker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 1'b0, bitValid = 1'b0, bitIn = 1'b0;
  logic done, match, doneR, matchR;
  logic [7:0] crcValue, crcValueR;
  int checks = 0, fails = 0;

  always #10 clk = ~clk; // 50 MHz

  idCrcChecker i_idCrcChecker (.clk(clk), .rstN(rstN), .clear(clear), .bitValid(bitValid),
    .bitIn(bitIn), .done(done), .match(match), .crcValue(crcValue));
  idCrcChecker #(.RESIDUE_CHECK(1'b1)) i_idCrcCheckerRes (.clk(clk), .rstN(rstN), .clear(clear),
    .bitValid(bitValid), .bitIn(bitIn), .done(doneR), .match(matchR), .crcValue(crcValueR));

  // {check byte xor mask, 56-bit body}
  localparam int NVEC = 6;
  localparam logic [63:0] VECS [NVEC] = '{
    {8'h00, 56'h00000001B81C02},
    {8'h01, 56'h00000001B81C02},
    {8'h00, 56'hFFFFFFFFFFFFFF},
    {8'h00, 56'h00000000000000},
    {8'h80, 56'h123456789ABCDE},
    {8'h00, 56'hA5A5A5A5A5A5A5}
  };

  function automatic logic [7:0] refCrc(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic fb = c[0] ^ d[i];
      c = (c >> 1) ^ (fb ? 8'h8C : 8'h00);
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); bitValid = 1'b1; bitIn = b;
    @(negedge clk); bitValid = 1'b0; bitIn = ~b;
  endtask

  task automatic doClear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic sendWord(input logic [63:0] w, input logic expMatch, input logic [7:0] expCrc);
    for (int i = 0; i < 64; i++) begin
      sendBit(w[i]);
      if (i == 55) chk("R2 crc of body", crcValue, expCrc);
      if (i == 62) chk("R4 done low before last bit", done, 0);
    end
    chk("R3 crc unchanged by check byte", crcValue, expCrc);
    chk("R4 done after last bit", done, 1);
    chk("R5 match verdict", match, expMatch);
    chk("R9 residue variant agrees", matchR, expMatch);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done at reset", done, 0);
    chk("R1 match at reset", match, 0);
    chk("R1 crc at reset", crcValue, 0);
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      logic [55:0] body = VECS[v][55:0];
      logic [7:0] good = refCrc(body);
      doClear();
      sendWord({good ^ VECS[v][63:56], body}, VECS[v][63:56] == 8'h00, good);
    end

    // R2 known body gives A2h
    doClear();
    sendWord({8'hA2, 56'h00000001B81C02}, 1'b1, 8'hA2);

    // R7 surplus strobes ignored
    for (int i = 0; i < 5; i++) sendBit(i[0]);
    chk("R7 done held", done, 1);
    chk("R7 match held", match, 1);
    chk("R7 crc held", crcValue, 8'hA2);

    // R6 clear clears
    doClear();
    chk("R6 done cleared", done, 0);
    chk("R6 match cleared", match, 0);
    chk("R6 crc cleared", crcValue, 0);

    // R8 bits without strobe ignored
    repeat (4) begin @(negedge clk); bitIn = 1'b1; end
    @(negedge clk);
    chk("R8 crc unchanged without strobe", crcValue, 0);

    // R6 clear beats simultaneous strobe: a 1 would give 8Ch
    @(negedge clk); clear = 1'b1; bitValid = 1'b1; bitIn = 1'b1;
    @(negedge clk); clear = 1'b0; bitValid = 1'b0;
    chk("R6 strobe with clear dropped", crcValue, 0);
    sendBit(1'b1);
    chk("R2 single one bit", crcValue, 8'h8C);

    // R5 corrupted body bit, original check byte
    doClear();
    sendWord({refCrc(56'hA5A5A5A5A5A5A5), 56'hA5A5A5A5A5A5A4}, 1'b0,
             refCrc(56'hA5A5A5A5A5A5A4));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule